// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block is the device-side front end of a single-data-rate SDRAM. On each rising clock edge it registers the control strobes, the bank select, the address bus, the clock enable and the per-byte masks. It turns them into commands and keeps the open or idle state and the open row of four banks. It also runs the burst column sequence. It reports the low-power mode that a low clock enable selects. For the data path it drives per-byte write strobes and a read output-enable that follows the read mask by two clocks.

A memory controller model or a device model wraps the block. It drives the usual command pins. It reads back the bank state, the burst column, the byte strobes and the power mode. The array, refresh timing and the serial presence-detect logic sit outside it.

Top module: `sdram_cmd_front`

## Requirements
- R1: A cycle with `cs_n` high is a no-operation: no bank state, row, burst or error changes because of it.
- R2: Commands are decoded from {cs_n, ras_n, cas_n, we_n}: 0111 NOP, 0011 ACTIVE, 0101 READ, 0100 WRITE, 0010 PRECHARGE, 0001 AUTO REFRESH, 0000 LOAD MODE, 0110 BURST STOP. ACTIVE to an idle bank `ba` sets `bank_open_o[ba]` and stores `addr` in `row_o[ba*12 +: 12]`, both visible the next cycle.
- R3: A legal READ or WRITE starts a burst. `burst_o` is high for BL cycles, starting the cycle after the command. `col_o` steps from the start column `addr[8:0]` and wraps inside the aligned block of BL columns.
- R4: LOAD MODE with `addr[2]` low sets the burst length from `addr[1:0]` (0,1,2,3 give 1,2,4,8), shown on `bl_o` the next cycle. With `addr[2]` high the length is kept. The reset length is 1.
- R5: PRECHARGE with `addr[10]` low closes only bank `ba`. With `addr[10]` high it closes all banks.
- R6: A READ or WRITE with `addr[10]` high closes its bank on the edge that ends the burst.
- R7: READ or WRITE to an idle bank, or ACTIVE to an open bank, raises `cmd_err_o` for one cycle and changes no bank state or row.
- R8: In each write burst cycle with `cke` high, `wr_be_o` equals the inverse of `dqm`. At all other times it is zero.
- R9: A read burst cycle with `cke` high and `dqm[i]` low sets `rd_oe_o[i]` two cycles later. A lane masked high, or any cycle outside a read burst, leaves that lane disabled two cycles later.
- R10: When `cke` is sampled low in run mode, `pwr_o` becomes, the next cycle: 4 clock suspend if a burst is running, else 2 active power-down if any bank is open, else 3 self refresh if the command is AUTO REFRESH, else 1 precharge power-down. 0 is run.
- R11: While `cke` is sampled low, commands are not executed and the burst column is frozen. The first cycle with `cke` sampled high returns `pwr_o` to 0 and resumes the burst.
- R12: BURST STOP ends a running burst, so that `burst_o` is low the next cycle, and closes no bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe |
| cas_n | input | 1 | Column strobe |
| we_n | input | 1 | Write strobe |
| ba | input | 2 | Bank select |
| addr | input | 12 | Address / opcode bus |
| dqm | input | 8 | Per-byte mask |
| bank_open_o | output | 4 | Open flag per bank |
| row_o | output | 48 | Open row per bank, 12 bits each |
| burst_o | output | 1 | Burst running |
| col_o | output | 9 | Current burst column |
| bl_o | output | 4 | Burst length |
| wr_be_o | output | 8 | Per-byte write strobes |
| rd_oe_o | output | 8 | Per-byte read output enables |
| pwr_o | output | 3 | Power mode |
| cmd_err_o | output | 1 | Illegal command pulse |

## Verification
A wrong bank flag shows up in the cycle after the command, either on `bank_open_o` or as a spurious or missing pulse on `cmd_err_o` for the next access to that bank. A wrong burst counter moves `col_o` off its wrap sequence in the next beat, and a missed burst end leaves a bank open a cycle too long. A stale mask pipeline shows up on `rd_oe_o` exactly two cycles after the beat. The power mode is checked one cycle after `cke` falls or rises, and the column held across a suspend is checked against the column before it.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
  typedef enum logic [2:0] {
    C_NOP, C_ACT, C_RD, C_WR, C_PRE, C_REF, C_LMR, C_BST
  } cmd_e;

  typedef enum logic [2:0] {
    PWR_RUN = 3'd0, PWR_PRE_PD = 3'd1, PWR_ACT_PD = 3'd2,
    PWR_SELF = 3'd3, PWR_SUSP = 3'd4
  } pwr_e;

  // burst length from the 2-bit mode code
  function automatic logic [3:0] bl_len(input logic [1:0] code);
    return 4'd1 << code;
  endfunction

  // column of beat idx, wrapping inside the aligned block of BL columns
  function automatic logic [15:0] burst_col(input logic [15:0] base,
                                            input logic [2:0] idx,
                                            input logic [1:0] code);
    logic [15:0] mask;
    mask = 16'(bl_len(code)) - 16'd1;
    return (base & ~mask) | ((base + 16'(idx)) & mask);
  endfunction
endpackage

// File: rtl/sdr_cmd_decode.sv
module sdr_cmd_decode
  import sdr_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  always_comb begin
    unique case ({cs_n, ras_n, cas_n, we_n})
      4'b0011: cmd = C_ACT;
      4'b0101: cmd = C_RD;
      4'b0100: cmd = C_WR;
      4'b0010: cmd = C_PRE;
      4'b0001: cmd = C_REF;
      4'b0000: cmd = C_LMR;
      4'b0110: cmd = C_BST;
      default: cmd = C_NOP;  // cs_n high masks everything
    endcase
  end
endmodule

// File: rtl/sdr_bank_track.sv
module sdr_bank_track
  import sdr_pkg::*;
#(
  parameter int NBANK  = 4,
  parameter int ADDR_W = 12,
  parameter int AP_BIT = 10,
  localparam int BA_W  = $clog2(NBANK)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  cmd_e                    cmd,
  input  logic [BA_W-1:0]         ba,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    ap_close,
  input  logic [BA_W-1:0]         ap_bank,
  output logic [NBANK-1:0]        open_q,
  output logic [NBANK*ADDR_W-1:0] rows_q,
  output logic                    rdwr_ok,
  output logic                    err_q
);
  logic sel_open, is_rdwr, bad_cmd, pre_all;

  assign sel_open = open_q[ba];
  assign is_rdwr  = (cmd == C_RD) || (cmd == C_WR);
  assign rdwr_ok  = en && is_rdwr && sel_open;
  assign bad_cmd  = en && ((is_rdwr && !sel_open) || (cmd == C_ACT && sel_open));
  assign pre_all  = en && (cmd == C_PRE) && addr[AP_BIT];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit;
    assign hit = (ba == BA_W'(b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_q[b] <= 1'b0;
        rows_q[b*ADDR_W +: ADDR_W] <= '0;
      end else if (en) begin
        if (cmd == C_ACT && hit && !open_q[b]) begin
          open_q[b] <= 1'b1;
          rows_q[b*ADDR_W +: ADDR_W] <= addr;
        end else if (cmd == C_PRE && (addr[AP_BIT] || hit)) begin
          open_q[b] <= 1'b0;
        end else if (ap_close && ap_bank == BA_W'(b)) begin
          open_q[b] <= 1'b0;
        end
      end
    end

    assert_act_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (en && cmd == C_ACT && hit && !open_q[b]) |=> open_q[b]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= bad_cmd;
  end

  assert_pre_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pre_all |=> (open_q == '0));
  assert_bad_act_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cmd == C_ACT && sel_open) |=> (err_q && $stable(rows_q)));
endmodule

// File: rtl/sdr_burst_ctl.sv
module sdr_burst_ctl
  import sdr_pkg::*;
#(
  parameter int COL_W = 9,
  parameter int BA_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             start,
  input  logic             start_rd,
  input  logic             start_ap,
  input  logic [BA_W-1:0]  start_bank,
  input  logic [COL_W-1:0] col_in,
  input  logic             stop,
  input  logic [1:0]       bl_code,
  output logic             burst_q,
  output logic             rd_q,
  output logic [COL_W-1:0] col_o,
  output logic             ap_close,
  output logic [BA_W-1:0]  ap_bank
);
  logic [2:0]       idx_q;
  logic [COL_W-1:0] base_q;
  logic             ap_q, last;

  assign last     = ({1'b0, idx_q} == bl_len(bl_code) - 4'd1);
  assign ap_close = en && burst_q && last && ap_q && !stop;
  assign col_o    = COL_W'(burst_col(16'(base_q), idx_q, bl_code));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_q <= 1'b0; rd_q <= 1'b0; ap_q <= 1'b0;
      idx_q <= '0; base_q <= '0; ap_bank <= '0;
    end else if (en) begin
      if (start) begin
        burst_q <= 1'b1; rd_q <= start_rd; ap_q <= start_ap;
        idx_q <= '0; base_q <= col_in; ap_bank <= start_bank;
      end else if (stop || (burst_q && last)) begin
        burst_q <= 1'b0;
      end else if (burst_q) begin
        idx_q <= idx_q + 3'd1;
      end
    end
  end

  assert_stop_ends_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (en && stop && !start) |=> !burst_q);
  assert_frozen_col_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(col_o));
endmodule

// File: rtl/sdr_lane_mask.sv
module sdr_lane_mask #(
  parameter int NBYTE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             wr_beat,
  input  logic             rd_beat,
  input  logic [NBYTE-1:0] dqm,
  output logic [NBYTE-1:0] wr_be,
  output logic [NBYTE-1:0] rd_oe
);
  logic [NBYTE-1:0] oe_s1;

  assign wr_be = wr_beat ? ~dqm : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_s1 <= '0;
      rd_oe <= '0;
    end else if (en) begin
      oe_s1 <= rd_beat ? ~dqm : '0;
      rd_oe <= oe_s1;
    end
  end

  for (genvar i = 0; i < NBYTE; i++) begin : g_lane
    assert_oe_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rd_beat, 2) && !$past(dqm[i], 2) && $past(en)) |-> rd_oe[i]);
  end
endmodule

// File: rtl/sdram_cmd_front.sv
module sdram_cmd_front
  import sdr_pkg::*;
#(
  parameter int NBANK  = 4,
  parameter int ADDR_W = 12,
  parameter int COL_W  = 9,
  parameter int NBYTE  = 8,
  parameter int AP_BIT = 10,
  localparam int BA_W  = $clog2(NBANK)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cke,
  input  logic                    cs_n,
  input  logic                    ras_n,
  input  logic                    cas_n,
  input  logic                    we_n,
  input  logic [BA_W-1:0]         ba,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [NBYTE-1:0]        dqm,
  output logic [NBANK-1:0]        bank_open_o,
  output logic [NBANK*ADDR_W-1:0] row_o,
  output logic                    burst_o,
  output logic [COL_W-1:0]        col_o,
  output logic [3:0]              bl_o,
  output logic [NBYTE-1:0]        wr_be_o,
  output logic [NBYTE-1:0]        rd_oe_o,
  output logic [2:0]              pwr_o,
  output logic                    cmd_err_o
);
  cmd_e            cmd;
  pwr_e            pwr_q;
  logic [1:0]      bl_code;
  logic            rdwr_ok, ap_close, burst_rd, wr_beat, rd_beat;
  logic [BA_W-1:0] ap_bank;

  sdr_cmd_decode u_dec (.cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd));

  sdr_bank_track #(.NBANK(NBANK), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT)) u_banks (
    .clk(clk), .rst_n(rst_n), .en(cke), .cmd(cmd), .ba(ba), .addr(addr),
    .ap_close(ap_close), .ap_bank(ap_bank), .open_q(bank_open_o),
    .rows_q(row_o), .rdwr_ok(rdwr_ok), .err_q(cmd_err_o));

  sdr_burst_ctl #(.COL_W(COL_W), .BA_W(BA_W)) u_burst (
    .clk(clk), .rst_n(rst_n), .en(cke), .start(rdwr_ok), .start_rd(cmd == C_RD),
    .start_ap(addr[AP_BIT]), .start_bank(ba), .col_in(addr[COL_W-1:0]),
    .stop(cke && cmd == C_BST), .bl_code(bl_code), .burst_q(burst_o),
    .rd_q(burst_rd), .col_o(col_o), .ap_close(ap_close), .ap_bank(ap_bank));

  assign wr_beat = cke && burst_o && !burst_rd;
  assign rd_beat = cke && burst_o && burst_rd;

  sdr_lane_mask #(.NBYTE(NBYTE)) u_lanes (
    .clk(clk), .rst_n(rst_n), .en(cke), .wr_beat(wr_beat), .rd_beat(rd_beat),
    .dqm(dqm), .wr_be(wr_be_o), .rd_oe(rd_oe_o));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bl_code <= 2'd0;
    else if (cke && cmd == C_LMR && !addr[2]) bl_code <= addr[1:0];
  end
  assign bl_o = bl_len(bl_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwr_q <= PWR_RUN;
    else if (cke) pwr_q <= PWR_RUN;
    else if (pwr_q == PWR_RUN) begin
      if (burst_o)             pwr_q <= PWR_SUSP;
      else if (|bank_open_o)   pwr_q <= PWR_ACT_PD;
      else if (cmd == C_REF)   pwr_q <= PWR_SELF;
      else                     pwr_q <= PWR_PRE_PD;
    end
  end
  assign pwr_o = pwr_q;

  assert_cs_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !ap_close) |=> $stable(bank_open_o));
  assert_suspend_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && pwr_q == PWR_RUN && burst_o) |=> pwr_q == PWR_SUSP);
  assert_exit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> pwr_q == PWR_RUN);
  assert_no_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> wr_be_o == '0);
  assert_ap_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ap_close |=> !bank_open_o[$past(ap_bank)]);
endmodule

// File: tb/sdram_cmd_front_bench.sv
`timescale 1ns/1ps
module sdram_cmd_front_bench;
  localparam logic [3:0] NOP = 4'b0111, ACT = 4'b0011, RD = 4'b0101, WR = 4'b0100,
                         PRE = 4'b0010, REF = 4'b0001, LMR = 4'b0000, BST = 4'b0110,
                         DESEL = 4'b1011;

  logic clk = 1'b0, rst_n = 1'b0, cke = 1'b1;
  logic cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic [11:0] addr = '0;
  logic [7:0] dqm = '0;
  logic [3:0] bank_open_o;
  logic [47:0] row_o;
  logic burst_o, cmd_err_o;
  logic [8:0] col_o;
  logic [3:0] bl_o;
  logic [7:0] wr_be_o, rd_oe_o;
  logic [2:0] pwr_o;

  sdram_cmd_front u_sdram_cmd_front (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .dqm(dqm), .bank_open_o(bank_open_o),
    .row_o(row_o), .burst_o(burst_o), .col_o(col_o), .bl_o(bl_o), .wr_be_o(wr_be_o),
    .rd_oe_o(rd_oe_o), .pwr_o(pwr_o), .cmd_err_o(cmd_err_o));

  always #2 clk = ~clk;  // 250 MHz

  typedef struct { int cyc; int sel; logic [63:0] val; string req; } item_t;
  item_t sb[$];
  int cyc = 0, now = 0, tests = 0, fails = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [63:0] observe(int sel);
    case (sel)
      0: return 64'(bank_open_o);
      1: return 64'(row_o);
      2: return 64'(burst_o);
      3: return 64'(col_o);
      4: return 64'(bl_o);
      5: return 64'(wr_be_o);
      6: return 64'(rd_oe_o);
      7: return 64'(pwr_o);
      default: return 64'(cmd_err_o);
    endcase
  endfunction

  // monitor: compare due scoreboard items, away from the rising edge
  always @(negedge clk) begin
    #1;
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].cyc == cyc) begin
        tests++;
        if (observe(sb[i].sel) !== sb[i].val) begin
          fails++;
          $display("FAIL %s sel=%0d cyc=%0d actual=%h expected=%h",
                   sb[i].req, sb[i].sel, cyc, observe(sb[i].sel), sb[i].val);
        end
        sb.delete(i);
      end
    end
  end

  task automatic drv(input logic [3:0] c, input logic [1:0] b, input logic [11:0] a,
                     input logic [7:0] m, input logic k);
    @(negedge clk);
    {cs_n, ras_n, cas_n, we_n} = c;
    ba = b; addr = a; dqm = m; cke = k;
    now = cyc;
  endtask

  task automatic exp(input int d, input int sel, input logic [63:0] v, input string r);
    sb.push_back('{now + d, sel, v, r});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drv(NOP, 2'd0, 12'h000, 8'h00, 1'b1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    tests++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    drv(NOP, 0, 0, 8'h00, 1);
    exp(0, 0, 0, "RST"); exp(0, 4, 1, "RST R4"); exp(0, 7, 0, "RST");
    exp(0, 2, 0, "RST"); exp(0, 6, 0, "RST"); exp(0, 8, 0, "RST");
    exp(0, 5, 0, "R8 idle");
    // R4 mode register
    drv(LMR, 0, 12'h002, 0, 1); exp(1, 4, 4, "R4 set BL4");
    drv(LMR, 0, 12'h005, 0, 1); exp(1, 4, 4, "R4 reserved code kept");
    // R2 activate bank 1
    drv(ACT, 1, 12'h123, 0, 1); exp(1, 0, 4'b0010, "R2 open");
    exp(1, 1, 48'h000_000_123_000, "R2 row");
    // R1 deselected activate
    drv(DESEL, 2, 12'h0FF, 0, 1); exp(1, 0, 4'b0010, "R1 masked"); exp(1, 8, 0, "R1 no err");
    // R7 illegal commands
    drv(ACT, 1, 12'h0AB, 0, 1); exp(1, 8, 1, "R7 act open");
    exp(1, 1, 48'h000_000_123_000, "R7 row kept");
    drv(RD, 0, 12'h000, 0, 1); exp(1, 8, 1, "R7 rd idle"); exp(1, 2, 0, "R7 no burst");
    drv(NOP, 0, 0, 0, 1); exp(1, 8, 0, "R7 pulse");
    // R3/R9 read burst, BL4, start column 6
    drv(RD, 1, 12'h006, 8'h00, 1);
    exp(1, 2, 1, "R3 burst"); exp(1, 3, 6, "R3 col"); exp(2, 3, 7, "R3 col");
    exp(3, 3, 4, "R3 wrap"); exp(4, 3, 5, "R3 col"); exp(5, 2, 0, "R3 length");
    exp(2, 5, 0, "R8 read no strobe");
    exp(3, 6, 8'hFF, "R9 oe"); exp(4, 6, 8'h0F, "R9 oe mask"); exp(5, 6, 8'hFF, "R9 oe");
    exp(6, 6, 8'h00, "R9 all masked"); exp(7, 6, 8'h00, "R9 after burst");
    drv(NOP, 0, 0, 8'h00, 1); drv(NOP, 0, 0, 8'hF0, 1);
    drv(NOP, 0, 0, 8'h00, 1); drv(NOP, 0, 0, 8'hFF, 1);
    idle(3);
    // R6/R8 write burst with auto-precharge, column 2
    drv(WR, 1, 12'h402, 8'h00, 1);
    exp(1, 3, 2, "R3 col"); exp(1, 5, 8'hFE, "R8 strobe");
    exp(2, 3, 3, "R3 col"); exp(2, 5, 8'h7F, "R8 strobe");
    exp(3, 3, 0, "R3 wrap"); exp(3, 5, 8'hFF, "R8 strobe");
    exp(4, 3, 1, "R3 col"); exp(4, 5, 8'h00, "R8 strobe"); exp(4, 0, 4'b0010, "R6 open");
    exp(5, 0, 4'b0000, "R6 closed"); exp(5, 2, 0, "R3 end"); exp(5, 5, 0, "R8 after");
    drv(NOP, 0, 0, 8'h01, 1); drv(NOP, 0, 0, 8'h80, 1);
    drv(NOP, 0, 0, 8'h00, 1); drv(NOP, 0, 0, 8'hFF, 1);
    idle(2);
    // R5 precharge single and all
    drv(ACT, 0, 12'h0AA, 0, 1); drv(ACT, 2, 12'h055, 0, 1); drv(ACT, 3, 12'h777, 0, 1);
    exp(1, 0, 4'b1101, "R2 three open"); exp(1, 1, 48'h777_055_123_0AA, "R2 rows");
    drv(PRE, 2, 12'h000, 0, 1); exp(1, 0, 4'b1001, "R5 single");
    drv(PRE, 0, 12'h400, 0, 1); exp(1, 0, 4'b0000, "R5 all");
    // R10/R11 power modes
    drv(NOP, 0, 0, 0, 0); exp(1, 7, 1, "R10 pre pd");
    drv(NOP, 0, 0, 0, 0); exp(1, 7, 1, "R10 hold");
    drv(NOP, 0, 0, 0, 1); exp(1, 7, 0, "R11 exit");
    drv(REF, 0, 0, 0, 0); exp(1, 7, 3, "R10 self refresh");
    drv(NOP, 0, 0, 0, 1); exp(1, 7, 0, "R11 exit");
    drv(ACT, 0, 12'h011, 0, 1);
    drv(ACT, 3, 12'h022, 0, 0); exp(1, 7, 2, "R10 active pd"); exp(1, 0, 4'b0001, "R11 cmd ignored");
    drv(NOP, 0, 0, 0, 1); exp(1, 7, 0, "R11 exit");
    // R10/R11 clock suspend during a read burst on bank 0
    drv(RD, 0, 12'h000, 0, 1);
    exp(1, 3, 0, "R3 col"); exp(2, 3, 1, "R11 col");
    exp(3, 7, 4, "R10 suspend"); exp(3, 3, 1, "R11 frozen"); exp(4, 3, 1, "R11 frozen");
    exp(4, 7, 4, "R10 suspend"); exp(5, 7, 0, "R11 exit"); exp(5, 3, 2, "R11 resume");
    exp(6, 3, 3, "R11 resume"); exp(7, 2, 0, "R3 end");
    drv(NOP, 0, 0, 0, 1); drv(NOP, 0, 0, 0, 0); drv(NOP, 0, 0, 0, 0);
    idle(4);
    // R12 burst stop
    drv(RD, 0, 12'h004, 0, 1); exp(1, 2, 1, "R12 running");
    drv(BST, 0, 0, 0, 1); exp(1, 2, 0, "R12 stopped"); exp(1, 0, 4'b0001, "R12 no close");
    idle(3);
    if (sb.size() != 0) begin
      tests++; fails++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", sb.size());
    end
    finish_run();
  end
endmodule